// File: doc/BRIEF.md
# Odd-Multiple Shared Shift-Select Multiplier

This block multiplies two unsigned 8-bit operands without building a partial-product array. A bank of constant multipliers forms the eight odd multiples of operand `a` (1·a, 3·a, up to 15·a) once. Each 4-bit slice of operand `b` then needs only a lookup. A slice select unit finds how many trailing zeros its slice has and strips them, which leaves an odd value. It uses that odd value to pick one of the shared multiples and shifts the pick back left by the stripped count. A slice of all zeros gives zero, because no odd multiple is zero. A combining adder weights each slice result by its position in `b` and adds the results.

The arithmetic is combinational. One output register stage holds the product and a matching valid flag. The product of a pair presented with `in_vld` high appears on `p` one clock later, with `out_vld` high. When `in_vld` is low, `p` keeps its last value. The multiple bank depends only on `a`, so a wider design can share it among several coefficient multipliers.

Top module: `cshm_mult`

## Requirements
- R1: While `rst_n` is low, `p` is 0 and `out_vld` is 0. An active reset clears a nonzero held product.
- R2: `out_vld` is high in exactly the cycles that follow a rising clock edge at which `in_vld` was high.
- R3: For every pair of 8-bit unsigned operands sampled with `in_vld` high, `p` equals `a*b` as a 16-bit unsigned value, one cycle later.
- R4: After a cycle in which `in_vld` is low, `p` keeps its previous value, whatever `a` and `b` do.
- R5: For a nonzero slice, the slice shift count is the number of trailing zero bits of that slice, from 0 to 3, and the slice shifted right by the count is odd.
- R6: For a nonzero slice, the multiple index is (q-1)/2, where q is the odd slice value. Rebuilding 2·index+1 and shifting it left by the count gives back the slice.
- R7: A slice of value 0 yields a slice result of 0.
- R8: Each slice result equals `a` times that 4-bit slice. The lower slice is `b[3:0]` and the upper slice is `b[7:4]`.
- R9: The upper slice result enters the product shifted left by 4 bits, and the lower slice result enters unshifted. Two examples: `b`=0xF0 gives 240·a, and `b`=0x0F gives 15·a.
- R10: 17 × 24 gives 408 and 85 × 36 gives 3060.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operands `a` and `b` are valid this cycle |
| a | input | 8 | Unsigned multiplicand; the odd multiples are formed from it |
| b | input | 8 | Unsigned multiplier; split into two 4-bit slices |
| out_vld | output | 1 | `p` holds a new product |
| p | output | 16 | Registered unsigned product |

## Verification
The assertions assume that `in_vld` is low during reset. They also assume that `a` and `b` settle before each rising edge, because the slice checks sample the combinational shift counts, indices and slice results directly at the edge. The bench holds `in_vld` low throughout reset and changes every input on the falling edge only.

The bench steps through all 65536 operand pairs, plus directed slices with each trailing-zero count. It drives random operand noise while `in_vld` is low, and this noise stays clear of the product registers.

// File: rtl/cshm_pkg.sv
package cshm_pkg;
  localparam int CSHM_A_W   = 8;
  localparam int CSHM_B_W   = 8;
  localparam int CSHM_NIB_W = 4;

  // odd multiplier constant held in bank entry k
  function automatic int odd_of(input int k);
    return 2 * k + 1;
  endfunction
endpackage

// File: rtl/cshm_precomp.sv
module cshm_precomp #(
  parameter int A_W   = cshm_pkg::CSHM_A_W,
  parameter int NIB_W = cshm_pkg::CSHM_NIB_W,
  localparam int ALPHA_N = 2 ** (NIB_W - 1),
  localparam int MULT_W  = A_W + NIB_W
) (
  input  logic [A_W-1:0]                 a,
  output logic [ALPHA_N-1:0][MULT_W-1:0] mults
);
  for (genvar k = 0; k < ALPHA_N; k++) begin : g_odd
    localparam logic [MULT_W-1:0] K_ODD = MULT_W'(cshm_pkg::odd_of(k));
    assign mults[k] = MULT_W'(a) * K_ODD;
  end
endmodule

// File: rtl/cshm_select.sv
module cshm_select #(
  parameter int A_W   = cshm_pkg::CSHM_A_W,
  parameter int NIB_W = cshm_pkg::CSHM_NIB_W,
  localparam int ALPHA_N = 2 ** (NIB_W - 1),
  localparam int MULT_W  = A_W + NIB_W,
  localparam int SH_W    = $clog2(NIB_W),
  localparam int IDX_W   = NIB_W - 1
) (
  input  logic [NIB_W-1:0]               nib,
  input  logic [ALPHA_N-1:0][MULT_W-1:0] mults,
  output logic [SH_W-1:0]                sh,
  output logic [IDX_W-1:0]               idx,
  output logic                           zero,
  output logic [MULT_W-1:0]              part
);
  // position of the lowest set bit; 0 for an all-zero slice
  function automatic logic [SH_W-1:0] trail_zeros(input logic [NIB_W-1:0] n);
    logic [SH_W-1:0] c;
    c = '0;
    for (int i = NIB_W - 1; i >= 0; i--) begin
      if (n[i]) c = SH_W'(i);
    end
    return c;
  endfunction

  logic [NIB_W-1:0]  odd_q;
  logic [MULT_W-1:0] picked;
  logic [MULT_W-1:0] restored;

  assign sh       = trail_zeros(nib);
  assign odd_q    = nib >> sh;
  assign idx      = odd_q[NIB_W-1:1];   // (q-1)/2 for odd q
  assign picked   = mults[idx];
  assign restored = picked << sh;
  assign zero     = (nib == '0);
  assign part     = zero ? '0 : restored;
endmodule

// File: rtl/cshm_fixed_add.sv
module cshm_fixed_add #(
  parameter int A_W    = cshm_pkg::CSHM_A_W,
  parameter int NIB_W  = cshm_pkg::CSHM_NIB_W,
  parameter int NUM_NIB = 2,
  localparam int MULT_W = A_W + NIB_W,
  localparam int P_W    = A_W + NIB_W * NUM_NIB
) (
  input  logic [NUM_NIB-1:0][MULT_W-1:0] part,
  output logic [P_W-1:0]                 sum
);
  logic [NUM_NIB:0][P_W-1:0] acc;
  assign acc[0] = '0;
  for (genvar i = 0; i < NUM_NIB; i++) begin : g_acc
    assign acc[i+1] = acc[i] + (P_W'(part[i]) << (i * NIB_W));
  end
  assign sum = acc[NUM_NIB];
endmodule

// File: rtl/cshm_mult.sv
module cshm_mult #(
  parameter int A_W   = cshm_pkg::CSHM_A_W,
  parameter int B_W   = cshm_pkg::CSHM_B_W,
  parameter int NIB_W = cshm_pkg::CSHM_NIB_W,
  localparam int NUM_NIB = B_W / NIB_W,
  localparam int ALPHA_N = 2 ** (NIB_W - 1),
  localparam int MULT_W  = A_W + NIB_W,
  localparam int SH_W    = $clog2(NIB_W),
  localparam int IDX_W   = NIB_W - 1,
  localparam int P_W     = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic           out_vld,
  output logic [P_W-1:0] p
);
  logic [ALPHA_N-1:0][MULT_W-1:0] mults;
  logic [NUM_NIB-1:0][SH_W-1:0]   nib_sh;
  logic [NUM_NIB-1:0][IDX_W-1:0]  nib_idx;
  logic [NUM_NIB-1:0]             nib_zero;
  logic [NUM_NIB-1:0][MULT_W-1:0] part;
  logic [P_W-1:0]                 prod_c;

  cshm_precomp #(.A_W(A_W), .NIB_W(NIB_W)) precomp_i (
    .a     (a),
    .mults (mults)
  );

  for (genvar i = 0; i < NUM_NIB; i++) begin : g_sel
    cshm_select #(.A_W(A_W), .NIB_W(NIB_W)) sel_i (
      .nib   (b[i*NIB_W +: NIB_W]),
      .mults (mults),
      .sh    (nib_sh[i]),
      .idx   (nib_idx[i]),
      .zero  (nib_zero[i]),
      .part  (part[i])
    );
  end

  cshm_fixed_add #(.A_W(A_W), .NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) add_i (
    .part (part),
    .sum  (prod_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      p       <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) p <= prod_c;
    end
  end
endmodule

// File: rtl/cshm_mult_chk.sv
module cshm_mult_chk #(
  parameter int A_W    = 8,
  parameter int B_W    = 8,
  parameter int NIB_W  = 4,
  localparam int NUM_NIB = B_W / NIB_W,
  localparam int MULT_W  = A_W + NIB_W,
  localparam int SH_W    = $clog2(NIB_W),
  localparam int IDX_W   = NIB_W - 1,
  localparam int P_W     = A_W + B_W
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_vld,
  input logic [A_W-1:0]                 a,
  input logic [B_W-1:0]                 b,
  input logic                           out_vld,
  input logic [P_W-1:0]                 p,
  input logic [NUM_NIB-1:0][SH_W-1:0]   nib_sh,
  input logic [NUM_NIB-1:0][IDX_W-1:0]  nib_idx,
  input logic [NUM_NIB-1:0]             nib_zero,
  input logic [NUM_NIB-1:0][MULT_W-1:0] part
);
  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_vld == $past(in_vld)));                                 // R2
  AST_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (p == P_W'($past(a)) * P_W'($past(b))));                   // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(p));                                              // R4

  for (genvar i = 0; i < NUM_NIB; i++) begin : g_nib
    logic [NIB_W-1:0] nib_in;
    logic [NIB_W-1:0] odd_chk;
    logic [NIB_W-1:0] rebuilt;
    assign nib_in  = b[i*NIB_W +: NIB_W];
    assign odd_chk = nib_in >> nib_sh[i];
    assign rebuilt = NIB_W'({nib_idx[i], 1'b1}) << nib_sh[i];

    AST_SHIFT_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      (nib_in != '0) |-> odd_chk[0]);                                     // R5
    AST_IDX_REBUILD: assert property (@(posedge clk) disable iff (!rst_n)
      (nib_in != '0) |-> (rebuilt == nib_in));                            // R6
    AST_ZERO_PART: assert property (@(posedge clk) disable iff (!rst_n)
      nib_zero[i] |-> (part[i] == '0));                                   // R7
    AST_PART_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      part[i] == MULT_W'(a) * MULT_W'(nib_in));                           // R8
  end
endmodule

bind cshm_mult cshm_mult_chk #(.A_W(A_W), .B_W(B_W), .NIB_W(NIB_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_vld   (in_vld),
  .a        (a),
  .b        (b),
  .out_vld  (out_vld),
  .p        (p),
  .nib_sh   (nib_sh),
  .nib_idx  (nib_idx),
  .nib_zero (nib_zero),
  .part     (part)
);

// File: tb/cshm_mult_tb_top.sv
`timescale 1ns/1ps
module cshm_mult_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [7:0]  a = '0;
  logic [7:0]  b = '0;
  logic        out_vld;
  logic [15:0] p;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  cshm_mult dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .a(a), .b(b), .out_vld(out_vld), .p(p)
  );

  task automatic check(input bit ok, input string tag,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one operand pair per falling edge, expectation pushed to the scoreboard
  task automatic drive(input logic [7:0] x, input logic [7:0] y, input string tag);
    item_t it;
    @(negedge clk);
    a = x; b = y; in_vld = 1'b1;
    it.exp = 16'(x) * 16'(y);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  // monitor: one result per cycle with out_vld high
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2 unexpected out_vld", 1, 0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(p == it.exp, it.tag, p, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check(p == 16'd0, "R1 reset p", p, 0);
    check(out_vld == 1'b0, "R1 reset out_vld", out_vld, 0);
    @(negedge clk);
    rst_n = 1'b1;

    drive(8'd17, 8'd24, "R10 17x24");
    drive(8'd85, 8'd36, "R10 85x36");
    drive(8'hC3, 8'h11, "R5 shift 0 both slices");
    drive(8'hC3, 8'h22, "R5 shift 1 both slices");
    drive(8'h9D, 8'h44, "R5 shift 2 both slices");
    drive(8'hFF, 8'h88, "R5 shift 3 both slices");
    drive(8'hFF, 8'hFF, "R6 top alphabet entry");
    drive(8'h5A, 8'h6C, "R6 index from 3 and 3");
    drive(8'hFF, 8'h50, "R7 lower slice zero");
    drive(8'hFF, 8'h05, "R7 upper slice zero");
    drive(8'h00, 8'hB7, "R8 zero multiplicand");
    drive(8'hA7, 8'h0D, "R8 lower slice only");
    drive(8'h01, 8'hF0, "R9 upper slice weight");
    drive(8'h01, 8'h0F, "R9 lower slice weight");
    go_idle();

    @(negedge clk);
    held = p;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      a = 8'($urandom);
      b = 8'($urandom);
    end
    @(negedge clk);
    check(p == held, "R4 idle hold", p, held);
    check(out_vld == 1'b0, "R2 idle out_vld", out_vld, 0);

    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        drive(8'(x), 8'(y), "R3 exhaustive");
      end
    end
    go_idle();
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R2 all results returned", sb_q.size(), 0);
    check(p == 16'd65025, "R3 last held product", p, 65025);

    rst_n = 1'b0;
    @(negedge clk);
    check(p == 16'd0, "R1 reset clears p", p, 0);
    check(out_vld == 1'b0, "R1 reset clears out_vld", out_vld, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule